// File: doc/BRIEF.md
# Packed Low-Half Vector Multiplier

This unit multiplies two packed vectors lane by lane on a 256-bit datapath. It treats every lane as a signed integer and keeps only the low half of each double-width product. Lanes are either sixteen 16-bit words or eight 32-bit dwords, chosen by an element-size select.

A form select decides how the upper 128 bits of the result are produced. They can be copied from the prior destination value, cleared to zero, or computed like the lower half. In the copy form the prior destination also serves as the first multiplicand, so the separate first-source input is not used.

Operands and both selects are captured together when `in_valid` is high. The result leaves the unit a fixed two cycles later with a one-cycle `out_valid` pulse. A new operation can be accepted on every cycle.

Top module: `pvmul_lo`

## Requirements
- R1: With `elem_sel`=0 (16-bit lanes), each result word holds bits 15:0 of the signed product of the matching words of the two multiplicands.
- R2: With `elem_sel`=1 (32-bit lanes), each result dword holds bits 31:0 of the signed product of the matching dwords of the two multiplicands.
- R3: With `form_sel`=0 (copy form), result bits 255:128 equal bits 255:128 of `dst_old` as sampled with the operation.
- R4: With `form_sel`=1 (clear form), result bits 255:128 are zero.
- R5: With `form_sel`=2 (full form), all lanes across bits 255:0 are computed: 16 word lanes or 8 dword lanes.
- R6: In the copy form the first multiplicand is `dst_old`, and `src_a` has no effect on the result.
- R7: No carry or product bit crosses a lane boundary. With every lane at its extreme values, each lane holds its own product independently of its neighbours.
- R8: `out_valid` is high exactly two cycles after the cycle in which `in_valid` was sampled high, for one cycle per operation, with issue allowed on every cycle.
- R9: The selects and operands are sampled only while `in_valid` is high. Changing them in later cycles does not alter a result already in flight.
- R10: While `rst_n` is low, and in the cycle after it is released, `out_valid` is 0 and `result` is all zeros.
- R11: `form_sel`=3 behaves as the clear form: lower lanes are computed and bits 255:128 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation issue strobe |
| elem_sel | input | 1 | Lane size: 0 = 16-bit, 1 = 32-bit |
| form_sel | input | 2 | Upper-half handling: 0 copy, 1 clear, 2 full, 3 clear |
| src_a | input | 256 | First multiplicand (unused in copy form) |
| src_b | input | 256 | Second multiplicand |
| dst_old | input | 256 | Prior destination value |
| out_valid | output | 1 | Result strobe |
| result | output | 256 | Packed result |

## Verification
Two functions can meet in one cycle. One operation's result can leave the unit while the next operation, which has a different lane size and form, is being captured, and a third operation's selects can change while it is idle. The bench provokes this by issuing operations back to back with alternating sizes and forms, with idle cycles in between in which inputs are scrambled. A scoreboard queue holds the expected vector and issue cycle for each operation. Every pulse is judged against the value the arithmetic reference computed for its own captured settings, and against its exact two-cycle arrival.

// File: rtl/pvmul_lo_pkg.sv
package pvmul_lo_pkg;

    typedef enum logic {
        ESZ_W16 = 1'b0,
        ESZ_W32 = 1'b1
    } esz_e;

    typedef enum logic [1:0] {
        FORM_COPY  = 2'd0,
        FORM_CLEAR = 2'd1,
        FORM_FULL  = 2'd2,
        FORM_RSVD  = 2'd3
    } form_e;

    localparam int unsigned SLICE_W = 32;
    localparam int unsigned HALF_SLICE_W = SLICE_W / 2;

endpackage

// File: rtl/pvmul_lane_array.sv
module pvmul_lane_array
    import pvmul_lo_pkg::*;
#(
    parameter int unsigned DATA_W = 256
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              wide_lane,
    output logic [DATA_W-1:0] prod
);
    localparam int unsigned NSLICE = DATA_W / SLICE_W;

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        logic [SLICE_W-1:0]      x, y, p_dw;
        logic [HALF_SLICE_W-1:0] p_lo, p_hi;

        assign x    = opa[g*SLICE_W +: SLICE_W];
        assign y    = opb[g*SLICE_W +: SLICE_W];
        // low half of a product is sign-agnostic, so modular multiply suffices
        assign p_dw = x * y;
        assign p_lo = x[HALF_SLICE_W-1:0] * y[HALF_SLICE_W-1:0];
        assign p_hi = x[SLICE_W-1:HALF_SLICE_W] * y[SLICE_W-1:HALF_SLICE_W];

        assign prod[g*SLICE_W +: SLICE_W] = wide_lane ? p_dw : {p_hi, p_lo};
    end
endmodule

// File: rtl/pvmul_upper_merge.sv
module pvmul_upper_merge
    import pvmul_lo_pkg::*;
#(
    parameter int unsigned DATA_W = 256
) (
    input  logic [DATA_W-1:0]   prod,
    input  logic [DATA_W/2-1:0] keep_hi,
    input  logic [1:0]          form,
    output logic [DATA_W-1:0]   merged
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] upper;

    always_comb begin
        unique case (form_e'(form))
            FORM_COPY: upper = keep_hi;
            FORM_FULL: upper = prod[DATA_W-1:HALF_W];
            default:   upper = '0;
        endcase
        merged = {upper, prod[HALF_W-1:0]};
    end
endmodule

// File: rtl/pvmul_lo.sv
module pvmul_lo
    import pvmul_lo_pkg::*;
#(
    parameter int unsigned DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              elem_sel,
    input  logic [1:0]        form_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] dst_old,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int unsigned HALF_W = DATA_W / 2;

    typedef struct packed {
        logic              cap_vld;
        logic              cap_wide;
        logic [1:0]        cap_form;
        logic [DATA_W-1:0] cap_a;
        logic [DATA_W-1:0] cap_b;
        logic [HALF_W-1:0] cap_keep;
        logic              res_vld;
        logic [DATA_W-1:0] res;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [DATA_W-1:0] prod_w;
    logic [DATA_W-1:0] merged_w;

    pvmul_lane_array #(.DATA_W(DATA_W)) u_lanes (
        .opa       (st_q.cap_a),
        .opb       (st_q.cap_b),
        .wide_lane (st_q.cap_wide),
        .prod      (prod_w)
    );

    pvmul_upper_merge #(.DATA_W(DATA_W)) u_merge (
        .prod    (prod_w),
        .keep_hi (st_q.cap_keep),
        .form    (st_q.cap_form),
        .merged  (merged_w)
    );

    always_comb begin
        st_d = st_q;
        st_d.cap_vld = in_valid;
        if (in_valid) begin
            st_d.cap_wide = elem_sel;
            st_d.cap_form = form_sel;
            st_d.cap_a    = (form_e'(form_sel) == FORM_COPY) ? dst_old : src_a;
            st_d.cap_b    = src_b;
            st_d.cap_keep = dst_old[DATA_W-1:HALF_W];
        end
        st_d.res_vld = st_q.cap_vld;
        if (st_q.cap_vld) begin
            st_d.res = merged_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.res_vld;
    assign result    = st_q.res;
endmodule

// File: rtl/pvmul_lo_chk.sv
module pvmul_lo_chk #(
    parameter int unsigned DATA_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              elem_sel,
    input logic [1:0]        form_sel,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] dst_old,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [1:0]  warm;
    logic [31:0] dw0_exp;
    logic        iss_clear, iss_copy, iss_dw_sep;

    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    assign dw0_exp    = src_a[31:0] * src_b[31:0];
    assign iss_clear  = in_valid && (form_sel == 2'd1 || form_sel == 2'd3);
    assign iss_copy   = in_valid && form_sel == 2'd0;
    assign iss_dw_sep = in_valid && elem_sel && form_sel != 2'd0;

    assert_issue_to_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    assert_out_has_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && warm >= 2'd2) |-> $past(in_valid, 2));

    assert_clear_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && warm >= 2'd2 && $past(iss_clear, 2)) |-> result[DATA_W-1:HALF_W] == '0);

    assert_copy_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && warm >= 2'd2 && $past(iss_copy, 2))
            |-> result[DATA_W-1:HALF_W] == $past(dst_old[DATA_W-1:HALF_W], 2));

    assert_dword_lane0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && warm >= 2'd2 && $past(iss_dw_sep, 2)) |-> result[31:0] == $past(dw0_exp, 2));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R10: assert (!out_valid && result == '0);
        end
    end
endmodule

bind pvmul_lo pvmul_lo_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .elem_sel  (elem_sel),
    .form_sel  (form_sel),
    .src_a     (src_a),
    .src_b     (src_b),
    .dst_old   (dst_old),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/pvmul_lo_test.sv
module pvmul_lo_test;
    localparam int W = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         elem_sel = 1'b0;
    logic [1:0]   form_sel = 2'd0;
    logic [W-1:0] src_a = '0, src_b = '0, dst_old = '0;
    logic         out_valid;
    logic [W-1:0] result;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W-1:0] exp;
        int           issued;
        string        tag;
    } item_t;

    item_t sb[$];

    pvmul_lo uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem_sel(elem_sel),
        .form_sel(form_sel), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .out_valid(out_valid), .result(result)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] ref_model(input logic esz, input logic [1:0] frm,
        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] d);
        logic [W-1:0] r, x;
        int span;
        x = (frm == 2'd0) ? d : a;
        span = (frm == 2'd2) ? W : W / 2;
        r = '0;
        if (esz) begin
            for (int i = 0; i < span / 32; i++) begin
                logic signed [63:0] p;
                p = $signed(x[i*32 +: 32]) * $signed(b[i*32 +: 32]);
                r[i*32 +: 32] = p[31:0];
            end
        end else begin
            for (int i = 0; i < span / 16; i++) begin
                logic signed [31:0] p;
                p = $signed(x[i*16 +: 16]) * $signed(b[i*16 +: 16]);
                r[i*16 +: 16] = p[15:0];
            end
        end
        if (frm == 2'd0) r[W-1:W/2] = d[W-1:W/2];
        return r;
    endfunction

    function automatic logic [W-1:0] fill16(input logic [15:0] v);
        return {16{v}};
    endfunction

    task automatic issue(input logic esz, input logic [1:0] frm, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] d, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; elem_sel = esz; form_sel = frm;
        src_a = a; src_b = b; dst_old = d;
        it.exp = ref_model(esz, frm, a, b, d);
        it.issued = cyc;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // R9: idle cycle that scrambles every sampled input
    task automatic idle_scramble();
        @(negedge clk);
        in_valid = 1'b0;
        elem_sel = ~elem_sel;
        form_sel = form_sel + 2'd1;
        src_a = ~src_a; src_b = {src_b[W-9:0], 8'h5A}; dst_old = ~dst_old;
    endtask

    function automatic logic [W-1:0] rnd();
        logic [W-1:0] v;
        for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R8: unexpected out_valid, actual=1 expected=0");
            end else begin
                item_t it;
                it = sb.pop_front();
                if (cyc - it.issued != 2) begin
                    bad++;
                    $display("FAIL R8 (%s): latency actual=%0d expected=2", it.tag, cyc - it.issued);
                end
                if (result !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, result, it.exp);
                end
            end
        end
    end

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    bad++;
                    $display("FAIL watchdog: actual=timeout expected=finish");
                    $display("test done: total=%0d bad=%0d", checks, bad);
                    $finish;
                end
            end
        join_none

        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== '0) begin
            bad++;
            $display("FAIL R10: actual=%b/%h expected=0/0", out_valid, result);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== '0) begin
            bad++;
            $display("FAIL R10 after release: actual=%b/%h expected=0/0", out_valid, result);
        end

        // R1 word corners: 0x8000*0x8000 -> 0, -1*-1 -> 1, wrap
        issue(1'b0, 2'd2, fill16(16'h8000), fill16(16'h8000), '0, "R1 most-negative words");
        issue(1'b0, 2'd2, fill16(16'hFFFF), fill16(16'hFFFF), '0, "R1 minus-one words");
        issue(1'b0, 2'd2, fill16(16'h7FFF), fill16(16'h7FFF), '0, "R7 word wrap all lanes");
        // R2 dword corners
        issue(1'b1, 2'd2, {8{32'h8000_0000}}, {8{32'h8000_0000}}, '0, "R2 most-negative dwords");
        issue(1'b1, 2'd2, {8{32'hFFFF_FFFF}}, {8{32'hFFFF_FFFF}}, '0, "R2 minus-one dwords");
        issue(1'b1, 2'd2, {8{32'h7FFF_FFFF}}, {8{32'h0001_0003}}, '0, "R7 dword wrap");
        // R7 alternating extreme lanes
        issue(1'b0, 2'd2, {8{32'h7FFF_8000}}, {8{32'h8000_FFFF}}, '0, "R7 mixed word lanes");
        issue(1'b1, 2'd2, {4{64'hFFFF_FFFF_7FFF_FFFF}}, {4{64'h7FFF_FFFF_FFFF_FFFF}}, '0, "R7 mixed dword lanes");
        idle_scramble();
        // R3 / R6 copy form, src_a garbage
        issue(1'b0, 2'd0, rnd(), rnd(), rnd(), "R3 R6 copy words");
        issue(1'b1, 2'd0, {W{1'b1}}, rnd(), rnd(), "R3 R6 copy dwords");
        // R4 clear form
        issue(1'b0, 2'd1, rnd(), rnd(), {W{1'b1}}, "R4 clear words");
        issue(1'b1, 2'd1, rnd(), rnd(), {W{1'b1}}, "R4 clear dwords");
        // R11 reserved code
        issue(1'b1, 2'd3, rnd(), rnd(), {W{1'b1}}, "R11 reserved form");
        issue(1'b0, 2'd3, rnd(), rnd(), rnd(), "R11 reserved form words");
        // R5 full form
        issue(1'b0, 2'd2, rnd(), rnd(), rnd(), "R5 full words");
        issue(1'b1, 2'd2, rnd(), rnd(), rnd(), "R5 full dwords");
        idle_scramble();
        idle_scramble();

        // R8 R9 mixed back-to-back and gapped traffic
        for (int n = 0; n < 60; n++) begin
            issue(1'($urandom), 2'($urandom), rnd(), rnd(), rnd(), "R8 R9 mixed stream");
            if (n % 7 == 3) idle_scramble();
        end

        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R8: pending actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule